// File: doc/BRIEF.md
# Acquisition Start Sequencer

This block is the run-control state machine of a detector interface board. When a start command arrives it checks the board's readiness. The front-end slow-control configuration must be complete, and neither the over-temperature flag nor the power-fault flag may be set. If any check fails, the block refuses to start and reports why. If all checks pass, it turns on the analog and digital supplies and waits a programmable settle time. It then resets the bunch-crossing counter with a single pulse and arms itself for a shared synchronisation pulse. Data taking starts on the cycle after that pulse. Every board that receives the same pulse therefore starts on the same clock edge, whenever its own command arrived.

While data taking is active, the block passes an event onward only when the event is validated and no trigger veto is present. Data taking ends when the front-end memory fills, when the analog memory saturates, or when a stop command arrives. The cause is latched in a status field. A static option then decides the next step. The block either raises a one-cycle readout request or falls straight back to idle with the supplies off.

Top module: `acq_seq`

## Requirements
- R1: After reset, every enable, strobe and request output is low, and both `stop_cause` and `err_code` read 0.
- R2: A start command in idle while `cfg_done` is low is refused. The supplies stay off and `err_code` becomes 1 (not configured).
- R3: A start command in idle with `cfg_done` high and `err_temp` high is refused with `err_code` 2. With `err_temp` low and `err_power` high it is refused with `err_code` 3. The temperature error takes priority over the power error, and the supplies stay off in both cases.
- R4: An accepted start clears `err_code` and `stop_cause` and raises both power enables from the next cycle on. Both enables stay high until the block is back in idle.
- R5: `bc_reset` is high for exactly one cycle. That cycle comes `settle_cycles`+1 cycles after the first cycle with power on.
- R6: `acq_en` rises on the cycle after the first `sync_pulse` seen after the `bc_reset` cycle. A sync pulse during the settle time has no effect.
- R7: `evt_take` equals `acq_en` AND `fe_valid` AND NOT `fe_veto`, within the same cycle.
- R8: During acquisition, memory full stops with `stop_cause` 1, saturation stops with 2, and a stop command stops with 3. When several coincide, the order of precedence is memory full, then saturation, then stop command. `stop_cause` holds until the next accepted start.
- R9: With `auto_readout` high, a stop is followed by one cycle of `readout_req` with the power still on, and then idle. With it low, the block goes straight to idle and `readout_req` stays low.
- R10: A stop command during the settle, counter-reset or sync-wait phase aborts to idle with `stop_cause` 3 and `acq_en` never rising.
- R11: A start command while the block is not idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start-acquisition command, one cycle |
| cmd_stop | input | 1 | External stop command, one cycle |
| cfg_done | input | 1 | Slow-control configuration complete |
| err_temp | input | 1 | Over-temperature error flag |
| err_power | input | 1 | Power-fault error flag |
| sync_pulse | input | 1 | Shared start synchronisation pulse |
| fe_mem_full | input | 1 | Front-end memory full |
| fe_sat | input | 1 | Analog memory saturated |
| fe_veto | input | 1 | Trigger veto / channel reset |
| fe_valid | input | 1 | Event validation |
| auto_readout | input | 1 | Request readout automatically after stop |
| settle_cycles | input | SW | Supply settle time in cycles |
| pwr_analog_en | output | 1 | Analog supply enable |
| pwr_digital_en | output | 1 | Digital supply enable |
| bc_reset | output | 1 | Bunch-counter reset pulse |
| acq_en | output | 1 | Acquisition enable |
| evt_take | output | 1 | Validated, unvetoed event during acquisition |
| readout_req | output | 1 | Readout request pulse |
| stop_cause | output | 2 | 0 none, 1 memory full, 2 saturation, 3 stop command |
| err_code | output | 2 | 0 none, 1 not configured, 2 temperature, 3 power fault |

## Verification
The stop conditions are where two functions fall on the same cycle. Memory full can coincide with saturation, and saturation can coincide with an external stop command. The bench raises each pair of inputs on the same clock edge during acquisition. It then judges the result by the latched `stop_cause`, which must name the higher-precedence cause, and by `acq_en` falling on the next cycle. A stop command that lands in the counter-reset cycle is also provoked. The bench checks that the reset pulse still completes and that acquisition never starts.

// File: rtl/acq_seq.sv
module acq_seq #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  input  logic          cfg_done,
  input  logic          err_temp,
  input  logic          err_power,
  input  logic          sync_pulse,
  input  logic          fe_mem_full,
  input  logic          fe_sat,
  input  logic          fe_veto,
  input  logic          fe_valid,
  input  logic          auto_readout,
  input  logic [SW-1:0] settle_cycles,
  output logic          pwr_analog_en,
  output logic          pwr_digital_en,
  output logic          bc_reset,
  output logic          acq_en,
  output logic          evt_take,
  output logic          readout_req,
  output logic [1:0]    stop_cause,
  output logic [1:0]    err_code
);
  typedef enum logic [2:0] {
    S_IDLE, S_SETTLE, S_BCRST, S_SYNC, S_ACQ, S_RDREQ
  } st_t;

  st_t          st;
  logic [SW-1:0] cnt;
  logic          busy;

  assign busy           = (st != S_IDLE);
  assign pwr_analog_en  = busy;
  assign pwr_digital_en = busy;
  assign bc_reset       = (st == S_BCRST);
  assign acq_en         = (st == S_ACQ);
  assign readout_req    = (st == S_RDREQ);
  assign evt_take       = acq_en & fe_valid & ~fe_veto;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      stop_cause <= 2'd0;
      err_code   <= 2'd0;
    end else begin
      case (st)
        S_IDLE: begin
          if (cmd_start) begin
            if (!cfg_done)      err_code <= 2'd1;
            else if (err_temp)  err_code <= 2'd2;
            else if (err_power) err_code <= 2'd3;
            else begin
              err_code   <= 2'd0;
              stop_cause <= 2'd0;
              cnt        <= settle_cycles;
              st         <= S_SETTLE;
            end
          end
        end
        S_SETTLE: begin
          if (cmd_stop) begin
            stop_cause <= 2'd3;
            st         <= S_IDLE;
          end else if (cnt == '0) begin
            st <= S_BCRST;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_BCRST: begin
          if (cmd_stop) begin
            stop_cause <= 2'd3;
            st         <= S_IDLE;
          end else begin
            st <= S_SYNC;
          end
        end
        S_SYNC: begin
          if (cmd_stop) begin
            stop_cause <= 2'd3;
            st         <= S_IDLE;
          end else if (sync_pulse) begin
            st <= S_ACQ;
          end
        end
        S_ACQ: begin
          if (fe_mem_full || fe_sat || cmd_stop) begin
            if (fe_mem_full) stop_cause <= 2'd1;
            else if (fe_sat) stop_cause <= 2'd2;
            else             stop_cause <= 2'd3;
            st <= auto_readout ? S_RDREQ : S_IDLE;
          end
        end
        S_RDREQ: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module acq_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_start,
  input logic       cfg_done,
  input logic       sync_pulse,
  input logic       fe_mem_full,
  input logic       pwr_analog_en,
  input logic       pwr_digital_en,
  input logic       bc_reset,
  input logic       acq_en,
  input logic       evt_take,
  input logic       readout_req,
  input logic [1:0] stop_cause,
  input logic [1:0] err_code
);
  AST_BCRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bc_reset |=> !bc_reset); // R5
  AST_ACQ_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    acq_en |-> (pwr_analog_en && pwr_digital_en)); // R4
  AST_ACQ_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_en) |-> $past(sync_pulse)); // R6
  AST_EVT_IN_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    evt_take |-> acq_en); // R7
  AST_MEMFULL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en && fe_mem_full) |=> (!acq_en && stop_cause == 2'd1)); // R8
  AST_RDREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    readout_req |=> (!readout_req && !pwr_analog_en)); // R9
  AST_UNCFG_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_analog_en && cmd_start && !cfg_done) |=> (!pwr_analog_en && err_code == 2'd1)); // R2
endmodule

bind acq_seq acq_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cfg_done(cfg_done),
  .sync_pulse(sync_pulse), .fe_mem_full(fe_mem_full),
  .pwr_analog_en(pwr_analog_en), .pwr_digital_en(pwr_digital_en),
  .bc_reset(bc_reset), .acq_en(acq_en), .evt_take(evt_take),
  .readout_req(readout_req), .stop_cause(stop_cause), .err_code(err_code)
);

// File: tb/sim_acq_seq.sv
module sim_acq_seq;
  logic clk = 0, rst_n = 0;
  logic cmd_start = 0, cmd_stop = 0, cfg_done = 0, err_temp = 0, err_power = 0;
  logic sync_pulse = 0, fe_mem_full = 0, fe_sat = 0, fe_veto = 0, fe_valid = 0;
  logic auto_readout = 0;
  logic [7:0] settle_cycles = 8'd3;
  logic pwr_analog_en, pwr_digital_en, bc_reset, acq_en, evt_take, readout_req;
  logic [1:0] stop_cause, err_code;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  acq_seq #(.SW(8)) u0 (.*);

  task automatic chk(string req, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start;
    cmd_start = 1; step(); cmd_start = 0;
  endtask

  task automatic go_acq(int settle);
    settle_cycles = 8'(settle);
    cfg_done = 1;
    pulse_start();
    step(settle + 2);
    sync_pulse = 1; step(); sync_pulse = 0;
  endtask

  task automatic t_reset;
    chk("R1 pwr", pwr_analog_en | pwr_digital_en, 0);
    chk("R1 strobes", bc_reset | acq_en | readout_req | evt_take, 0);
    chk("R1 codes", {stop_cause, err_code}, 0);
  endtask

  task automatic t_refuse;
    cfg_done = 0; pulse_start();
    chk("R2 err", err_code, 1);
    chk("R2 pwr", pwr_analog_en, 0);
    cfg_done = 1; err_temp = 1; err_power = 1; pulse_start();
    chk("R3 temp prio", err_code, 2);
    err_temp = 0; pulse_start();
    chk("R3 power", err_code, 3);
    chk("R3 pwr off", pwr_digital_en, 0);
    err_power = 0;
  endtask

  task automatic t_sequence;
    settle_cycles = 8'd3; cfg_done = 1;
    pulse_start();
    chk("R4 pwr on", {pwr_analog_en, pwr_digital_en}, 3);
    chk("R4 err clr", err_code, 0);
    for (int i = 1; i <= 3; i++) begin
      if (i == 2) sync_pulse = 1;
      step();
      sync_pulse = 0;
      chk("R5 no early bcrst", bc_reset, 0);
    end
    step();
    chk("R5 bcrst pulse", bc_reset, 1);
    chk("R6 no acq at bcrst", acq_en, 0);
    step();
    chk("R5 bcrst single", bc_reset, 0);
    chk("R6 early sync ignored", acq_en, 0);
    step(2);
    chk("R6 waiting", acq_en, 0);
    sync_pulse = 1; step(); sync_pulse = 0;
    chk("R6 acq on", acq_en, 1);
    fe_valid = 1; #1;
    chk("R7 take", evt_take, 1);
    fe_veto = 1; #1;
    chk("R7 veto", evt_take, 0);
    fe_veto = 0; fe_valid = 0;
    pulse_start();
    chk("R11 start ignored", acq_en, 1);
    auto_readout = 0; cmd_stop = 1; step(); cmd_stop = 0;
    chk("R8 ext stop", stop_cause, 3);
    chk("R9 no rdreq", readout_req, 0);
    chk("R9 idle", pwr_analog_en, 0);
    fe_valid = 1; #1;
    chk("R7 idle no take", evt_take, 0);
    fe_valid = 0;
  endtask

  task automatic t_collide;
    auto_readout = 1;
    go_acq(1);
    chk("R6 acq", acq_en, 1);
    fe_mem_full = 1; fe_sat = 1; step(); fe_mem_full = 0; fe_sat = 0;
    chk("R8 full over sat", stop_cause, 1);
    chk("R9 rdreq", readout_req, 1);
    chk("R9 pwr kept", pwr_analog_en, 1);
    step();
    chk("R9 rdreq single", readout_req, 0);
    chk("R9 idle after", pwr_analog_en, 0);
    auto_readout = 0;
    go_acq(0);
    chk("R4 cause clr", stop_cause, 0);
    fe_sat = 1; cmd_stop = 1; step(); fe_sat = 0; cmd_stop = 0;
    chk("R8 sat over stop", stop_cause, 2);
    chk("R8 acq off", acq_en, 0);
  endtask

  task automatic t_abort;
    settle_cycles = 8'd2; cfg_done = 1;
    pulse_start();
    step(3);
    chk("R10 at bcrst", bc_reset, 1);
    cmd_stop = 1; step(); cmd_stop = 0;
    chk("R10 cause", stop_cause, 3);
    chk("R10 idle", pwr_analog_en, 0);
    sync_pulse = 1; step(); sync_pulse = 0;
    chk("R10 no acq", acq_en, 0);
  endtask

  initial begin
    fork
      begin
        step(3); rst_n = 1; step();
        t_reset();
        t_refuse();
        t_sequence();
        t_collide();
        t_abort();
      end
      begin
        #2000000;
        n_run++; n_fail++;
        $display("FAIL watchdog got=1 exp=0");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule